// File: doc/BRIEF.md
# SPI Flash Command Transaction Engine

This block issues one single-lane SPI flash command per start pulse. A transaction always begins with an 8-bit opcode. An address field, a stretch of dummy clocks, an outgoing data field and an incoming data field may follow. Each of these four can be turned on or off on its own. The engine drives the serial clock, the active-low chip select, the serial output and a write-protect pin. It samples the serial input and returns a 32-bit result word.

A controller sets the opcode, the phase lengths, the address, the outgoing data, the clock divider and the write-protect level, then pulses `start`. The engine captures the whole configuration on the accepted start, so the inputs may change freely while it runs. `busy` stays high while chip select is low. `done` pulses for one cycle as chip select is released, and `rdata` updates in that same cycle. A parameter-table read is one example: opcode 0x5A, a 24-bit address, 8 dummy clocks and 8 to 32 input bits.

Top module: `spi_cmd_engine`

## Requirements
- R1: Every transaction starts with exactly 8 opcode bits on `mosi`, bit 7 first.
- R2: When `addr_bits` is nonzero, the low `addr_bits` bits of `addr` follow the opcode, most significant of those bits first. When `addr_bits` is zero, no address clocks are produced.
- R3: Dummy clocks are produced only when the effective `miso_bits` is nonzero. Their count is `dummy_cycles + pad_cycles`, and `mosi` is low during them. When the input length is zero, no dummy clocks occur, whatever the dummy and pad inputs hold.
- R4: When `mosi_bits` is nonzero, the low `mosi_bits` bits of `mosi_data` are sent after the dummy clocks, most significant first. A length of zero sends nothing.
- R5: The input phase, which comes last, samples `miso` for `miso_bits` clocks. The first sampled bit lands in `rdata[miso_bits-1]` and the last in `rdata[0]`. All bits at or above `miso_bits` read as zero. A 32-bit read fills the whole word, and a read length of zero returns zero.
- R6: A value above 32 on `addr_bits`, `mosi_bits` or `miso_bits` behaves exactly as 32.
- R7: The engine uses SPI mode 0. `sclk` is low whenever chip select is inactive, and `mosi` never changes while `sclk` is high, so that `miso` is sampled on the rising edge.
- R8: With h = max(`sck_half`, 1) and N total clocked bits, `cs_n` stays low for exactly h*(2N+1) system cycles. This covers a half-period lead-in, N clock periods, and a half-period tail.
- R9: `wp` is high whenever the engine is idle. During a transaction it holds the `wp_level` value captured at start.
- R10: `busy` is high exactly while `cs_n` is low. A `start` pulse while busy is ignored, and so is any change on the configuration inputs.
- R11: `done` is high for exactly one cycle, in the cycle where `cs_n` returns high. `rdata` changes only in that cycle.
- R12: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `wp`=1, `busy`=0, `done`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction when idle |
| opcode | input | 8 | Command byte |
| addr_bits | input | 6 | Address length in bits, 0 skips the phase |
| addr | input | 32 | Address value, low-aligned |
| dummy_cycles | input | 8 | Requested dummy clocks |
| pad_cycles | input | 4 | Extra dummy clocks added before a read |
| mosi_bits | input | 6 | Outgoing data length in bits |
| mosi_data | input | 32 | Outgoing data, low-aligned |
| miso_bits | input | 6 | Incoming data length in bits |
| wp_level | input | 1 | Write-protect level during the transaction |
| sck_half | input | 8 | System cycles per serial-clock half period (0 acts as 1) |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| wp | output | 1 | Write-protect pin |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Received word, upper bits zeroed |

## Verification
The hardest cases to reach from the ports are the phase-skipping combinations. One is a read with zero requested dummy clocks but a nonzero pad. Another is nonzero dummy and pad values combined with a zero input length, where every dummy clock must disappear. A third is an out-of-range length that must fold to 32. The stimulus reaches these with directed transactions, and then sweeps random mixes of every phase length and divider setting. A serial flash model in the bench records each bit on the rising clock edge and feeds a random response stream. It can also fire a second start pulse with scrambled configuration in the middle of a transaction, to show that the captured settings survive.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Transaction phases in wire order; TAIL is the closing half period.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_TX,
    PH_RX,
    PH_TAIL
  } phase_e;

  localparam int OPCODE_W = 8;

endpackage

// File: rtl/spi_sck_div.sv
// Produces one-cycle ticks every max(half,1) system cycles while run is high.
module spi_sck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (half == '0) ? DIV_W'(1) : half;
  assign tick = run && (cnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_rx_capture.sv
// Shifts in serial input bits and publishes the word when the transaction closes.
module spi_rx_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              miso,
  input  logic              commit,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      rdata <= '0;
    end else begin
      if (clear) begin
        sh_q <= '0;
      end else if (sample) begin
        sh_q <= {sh_q[DATA_W-2:0], miso};
      end
      if (commit) begin
        rdata <= sh_q;
      end
    end
  end

endmodule

// File: rtl/spi_phase_ctrl.sv
// Phase sequencer: captures configuration, walks the phases, drives the pins.
module spi_phase_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 6,
  parameter int DUMMY_W = 8,
  parameter int PAD_W   = 4,
  parameter int DIV_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [OPCODE_W-1:0] opcode,
  input  logic [LEN_W-1:0]    addr_bits,
  input  logic [DATA_W-1:0]   addr,
  input  logic [DUMMY_W-1:0]  dummy_cycles,
  input  logic [PAD_W-1:0]    pad_cycles,
  input  logic [LEN_W-1:0]    mosi_bits,
  input  logic [DATA_W-1:0]   mosi_data,
  input  logic [LEN_W-1:0]    miso_bits,
  input  logic                wp_level,
  input  logic [DIV_W-1:0]    sck_half,
  input  logic                tick,
  output logic [DIV_W-1:0]    half_q,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                wp,
  output logic                busy,
  output logic                done,
  output logic                rx_clear,
  output logic                rx_sample,
  output logic                rx_commit
);

  localparam int SUM_W = ((DUMMY_W > PAD_W) ? DUMMY_W : PAD_W) + 1;
  localparam int CNT_W = (SUM_W > LEN_W) ? SUM_W : LEN_W;

  phase_e              ph_q, nxt_ph;
  logic [CNT_W-1:0]    cnt_q, nxt_len;
  logic [DATA_W-1:0]   tx_sh_q, nxt_data;
  logic [LEN_W-1:0]    a_len_q, t_len_q, r_len_q;
  logic [CNT_W-1:0]    d_len_q;
  logic [DATA_W-1:0]   addr_q, tdata_q;
  logic [LEN_W-1:0]    r_len_in;
  logic                accept;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v > LEN_W'(DATA_W)) return LEN_W'(DATA_W);
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] v,
                                                   input logic [LEN_W-1:0]  n);
    if (n == '0) return '0;
    return v << (DATA_W - int'(n));
  endfunction

  assign accept    = start && !busy;
  assign r_len_in  = clamp_len(miso_bits);
  assign rx_clear  = accept;
  assign rx_sample = tick && (ph_q == PH_RX) && !sclk;
  assign rx_commit = tick && (ph_q == PH_TAIL);

  // Choose the next enabled phase after the current one.
  always_comb begin
    nxt_ph = PH_TAIL;
    unique case (ph_q)
      PH_CMD: begin
        if (a_len_q != '0)      nxt_ph = PH_ADDR;
        else if (d_len_q != '0) nxt_ph = PH_DUMMY;
        else if (t_len_q != '0) nxt_ph = PH_TX;
        else if (r_len_q != '0) nxt_ph = PH_RX;
      end
      PH_ADDR: begin
        if (d_len_q != '0)      nxt_ph = PH_DUMMY;
        else if (t_len_q != '0) nxt_ph = PH_TX;
        else if (r_len_q != '0) nxt_ph = PH_RX;
      end
      PH_DUMMY: begin
        if (t_len_q != '0)      nxt_ph = PH_TX;
        else if (r_len_q != '0) nxt_ph = PH_RX;
      end
      PH_TX: begin
        if (r_len_q != '0)      nxt_ph = PH_RX;
      end
      default: nxt_ph = PH_TAIL;
    endcase
  end

  // Length and shift content of the phase about to start.
  always_comb begin
    nxt_len  = CNT_W'(1);
    nxt_data = '0;
    case (nxt_ph)
      PH_ADDR: begin
        nxt_len  = CNT_W'(a_len_q);
        nxt_data = left_align(addr_q, a_len_q);
      end
      PH_DUMMY: nxt_len = d_len_q;
      PH_TX: begin
        nxt_len  = CNT_W'(t_len_q);
        nxt_data = left_align(tdata_q, t_len_q);
      end
      PH_RX:   nxt_len = CNT_W'(r_len_q);
      default: nxt_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      a_len_q <= '0;
      t_len_q <= '0;
      r_len_q <= '0;
      d_len_q <= '0;
      addr_q  <= '0;
      tdata_q <= '0;
      half_q  <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      wp      <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ph_q    <= PH_CMD;
        cnt_q   <= CNT_W'(OPCODE_W - 1);
        tx_sh_q <= {opcode, {(DATA_W-OPCODE_W){1'b0}}};
        mosi    <= opcode[OPCODE_W-1];
        a_len_q <= clamp_len(addr_bits);
        t_len_q <= clamp_len(mosi_bits);
        r_len_q <= r_len_in;
        d_len_q <= (r_len_in != '0) ? (CNT_W'(dummy_cycles) + CNT_W'(pad_cycles)) : '0;
        addr_q  <= addr;
        tdata_q <= mosi_data;
        half_q  <= sck_half;
        wp      <= wp_level;
        cs_n    <= 1'b0;
        busy    <= 1'b1;
      end else if (busy && tick) begin
        if (ph_q == PH_TAIL) begin
          ph_q <= PH_IDLE;
          cs_n <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
          wp   <= 1'b1;
          mosi <= 1'b0;
        end else if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (cnt_q != '0) begin
            cnt_q   <= cnt_q - CNT_W'(1);
            mosi    <= tx_sh_q[DATA_W-2];
            tx_sh_q <= tx_sh_q << 1;
          end else begin
            ph_q    <= nxt_ph;
            cnt_q   <= nxt_len - CNT_W'(1);
            tx_sh_q <= nxt_data;
            mosi    <= nxt_data[DATA_W-1];
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 6,
  parameter int DUMMY_W = 8,
  parameter int PAD_W   = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         opcode,
  input  logic [LEN_W-1:0]   addr_bits,
  input  logic [DATA_W-1:0]  addr,
  input  logic [DUMMY_W-1:0] dummy_cycles,
  input  logic [PAD_W-1:0]   pad_cycles,
  input  logic [LEN_W-1:0]   mosi_bits,
  input  logic [DATA_W-1:0]  mosi_data,
  input  logic [LEN_W-1:0]   miso_bits,
  input  logic               wp_level,
  input  logic [DIV_W-1:0]   sck_half,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               wp,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);

  logic             tick;
  logic [DIV_W-1:0] half_q;
  logic             rx_clear, rx_sample, rx_commit;

  spi_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .half (half_q),
    .tick (tick)
  );

  spi_phase_ctrl #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .DUMMY_W(DUMMY_W),
    .PAD_W  (PAD_W),
    .DIV_W  (DIV_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .opcode      (opcode),
    .addr_bits   (addr_bits),
    .addr        (addr),
    .dummy_cycles(dummy_cycles),
    .pad_cycles  (pad_cycles),
    .mosi_bits   (mosi_bits),
    .mosi_data   (mosi_data),
    .miso_bits   (miso_bits),
    .wp_level    (wp_level),
    .sck_half    (sck_half),
    .tick        (tick),
    .half_q      (half_q),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .wp          (wp),
    .busy        (busy),
    .done        (done),
    .rx_clear    (rx_clear),
    .rx_sample   (rx_sample),
    .rx_commit   (rx_commit)
  );

  spi_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clear (rx_clear),
    .sample(rx_sample),
    .miso  (miso),
    .commit(rx_commit),
    .rdata (rdata)
  );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              cs_n,
  input logic              mosi,
  input logic              wp,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);

  // R7
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);

  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) sclk |-> $stable(mosi));

  // R9
  wp_idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> wp);

  // R10
  busy_cs_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !cs_n);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> done);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rdata));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .sclk (sclk),
  .cs_n (cs_n),
  .mosi (mosi),
  .wp   (wp),
  .busy (busy),
  .done (done),
  .rdata(rdata)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [5:0]  addr_bits = '0;
  logic [31:0] addr = '0;
  logic [7:0]  dummy_cycles = '0;
  logic [3:0]  pad_cycles = '0;
  logic [5:0]  mosi_bits = '0;
  logic [31:0] mosi_data = '0;
  logic [5:0]  miso_bits = '0;
  logic        wp_level = 1'b0;
  logic [7:0]  sck_half = 8'd1;
  logic        miso;
  logic        sclk, cs_n, mosi, wp, busy, done;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  int base   = 0;
  logic stream   [0:511];
  logic log_bits [0:511];

  always #5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .addr_bits(addr_bits),
    .addr(addr), .dummy_cycles(dummy_cycles), .pad_cycles(pad_cycles),
    .mosi_bits(mosi_bits), .mosi_data(mosi_data), .miso_bits(miso_bits),
    .wp_level(wp_level), .sck_half(sck_half), .miso(miso), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .wp(wp), .busy(busy), .done(done), .rdata(rdata)
  );

  // Flash model: records mosi and advances the response on each rising clock.
  assign miso = stream[9'(rises - base)];
  always @(posedge sclk) begin
    log_bits[9'(rises - base)] <= mosi;
    rises <= rises + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampl(input int v);
    return (v > 32) ? 32 : v;
  endfunction

  task automatic xfer(input logic [7:0] op, input int alen, input logic [31:0] ad,
                      input int dn, input int pn, input int tlen, input logic [31:0] td,
                      input int rlen, input int hf, input bit wpl, input bit poke);
    int ea, ed, et, er, nb, eh, lowcnt, wpbad, busybad, mism;
    logic [31:0] exp_r;
    logic eb;
    ea = clampl(alen); et = clampl(tlen); er = clampl(rlen);
    ed = (er != 0) ? dn + pn : 0;
    nb = 8 + ea + ed + et + er;
    eh = (hf == 0) ? 1 : hf;
    for (int i = 0; i < 512; i++) stream[i] = 1'($urandom);
    @(negedge clk);
    opcode = op; addr_bits = 6'(alen); addr = ad; dummy_cycles = 8'(dn);
    pad_cycles = 4'(pn); mosi_bits = 6'(tlen); mosi_data = td; miso_bits = 6'(rlen);
    sck_half = 8'(hf); wp_level = wpl;
    base = rises;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      opcode = ~op; addr_bits = 6'd5; addr = ~ad; dummy_cycles = 8'd3; pad_cycles = 4'd2;
      mosi_bits = 6'd7; mosi_data = ~td; miso_bits = 6'd9; sck_half = 8'd2; wp_level = ~wpl;
    end
    lowcnt = 0; wpbad = 0; busybad = 0;
    while (cs_n == 1'b0 && lowcnt < 20000) begin
      lowcnt++;
      if (wp !== wpl) wpbad++;
      if (busy !== 1'b1) busybad++;
      if (poke && lowcnt == 3) start = 1'b1;
      if (poke && lowcnt == 4) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    // R8 chip-select low time
    chk(lowcnt == eh * (2 * nb + 1), "R8 cs_n low cycles", 64'(lowcnt), 64'(eh * (2 * nb + 1)));
    // R3 total clocked bits (dummy count included)
    chk((rises - base) == nb, "R3 clocked bit count", 64'(rises - base), 64'(nb));
    mism = 0;
    for (int j = 0; j < nb && j < 512; j++) begin
      if (j < 8) eb = op[7 - j];
      else if (j < 8 + ea) eb = ad[ea - 1 - (j - 8)];
      else if (j < 8 + ea + ed) eb = 1'b0;
      else if (j < 8 + ea + ed + et) eb = td[et - 1 - (j - 8 - ea - ed)];
      else eb = 1'b0;
      if (log_bits[j] !== eb) mism++;
    end
    // R1 R2 R3 R4 serial output stream
    chk(mism == 0, "R1 R2 R3 R4 mosi bit mismatches", 64'(mism), 64'd0);
    exp_r = '0;
    for (int k = 0; k < er; k++) exp_r[er - 1 - k] = stream[8 + ea + ed + et + k];
    // R5 returned word
    chk(rdata === exp_r, "R5 rdata", 64'(rdata), 64'(exp_r));
    // R9 write-protect level during transfer, high afterwards
    chk(wpbad == 0 && wp === 1'b1, "R9 wp level", 64'(wpbad), 64'd0);
    // R10 busy tracks chip select; mid-transfer start ignored
    chk(busybad == 0 && busy === 1'b0, "R10 busy", 64'(busybad), 64'd0);
    // R11 done on release, one cycle
    chk(done === 1'b1, "R11 done at release", 64'(done), 64'd1);
    @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", 64'(done), 64'd0);
    // R7 clock idles low
    chk(sclk === 1'b0 && cs_n === 1'b1, "R7 idle sclk", 64'(sclk), 64'd0);
  endtask

  initial begin
    #(10 * 190000);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk({cs_n, sclk, mosi, wp, busy, done} === 6'b100100, "R12 reset pins",
        64'({cs_n, sclk, mosi, wp, busy, done}), 64'b100100);
    chk(rdata === 32'd0, "R12 reset rdata", 64'(rdata), 64'd0);

    // R1 opcode only
    xfer(8'hA5, 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, 1'b0, 1'b0);
    // parameter-table read: 24-bit address, 8 dummies, 1..4 bytes (R2 R3 R5)
    xfer(8'h5A, 24, 32'h00_0010, 8, 0, 0, 32'h0, 8, 2, 1'b1, 1'b0);
    xfer(8'h5A, 24, 32'hFF_ABCDE, 8, 1, 0, 32'h0, 32, 1, 1'b0, 1'b0);
    // R3 dummy and pad dropped when nothing is read
    xfer(8'h06, 0, 32'h0, 9, 5, 16, 32'h1234_BEEF, 0, 1, 1'b1, 1'b0);
    // R3 pad alone before a read
    xfer(8'h9F, 0, 32'h0, 0, 3, 0, 32'h0, 24, 3, 1'b0, 1'b0);
    // R4 write then read
    xfer(8'h01, 8, 32'h77, 0, 0, 32, 32'hDEAD_BEEF, 13, 1, 1'b1, 1'b0);
    // R6 oversize lengths fold to 32
    xfer(8'h3C, 40, 32'h8000_0001, 2, 0, 63, 32'hC001_CAFE, 45, 1, 1'b0, 1'b0);
    // R8 divider setting 0 behaves as 1; R10 start while busy ignored
    xfer(8'hC3, 16, 32'hAAAA_5555, 4, 2, 5, 32'h15, 7, 0, 1'b1, 1'b1);
    xfer(8'h0F, 32, 32'h1357_9BDF, 1, 0, 1, 32'h1, 1, 4, 1'b0, 1'b1);

    for (int n = 0; n < 30; n++) begin
      xfer(8'($urandom), int'($urandom % 34), $urandom, int'($urandom % 13),
           int'($urandom % 4), int'($urandom % 34), $urandom, int'($urandom % 34),
           int'($urandom % 4), 1'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule